// File: doc/BRIEF.md
# Down-Counting Timer Bank

A memory-mapped bank of independent 32-bit down-counters for two jobs: an operating-system tick that fires after a programmed interval, and a free-running timebase that software reads and inverts to get an up-counting clock. Each channel keeps two values. The period register holds what software last wrote. The live counter is the value that actually counts down. Software never writes the live counter directly. It reaches the counter either through an immediate copy from the period register, or through an automatic reload when the count runs out.

Each channel chooses its count pulses from a small set of enable inputs, or it counts on every clock. When the live count goes from one to zero, the channel raises a sticky flag. The flag drives that channel's interrupt line only while the channel's enable bit is on. Every register has a plain address and two alias addresses. A write to one alias ORs bits into the register and a write to the other clears them, so software can change single control bits without a read-modify-write. A block control register holds a soft-reset bit. A read-only word reports the design version.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every block, control, live and period register reads 0. A read strobe on `bus_rd` returns the addressed register on `bus_rdata` one cycle later, sampling the value held before that edge.
- R2: The live counter drops by one on each selected tick. Select field ctl[3:0] = 0xF ticks every cycle, and 0x8+k ticks on `tick_src[k]` (0xB is the slow reference on input 3). Any other select value freezes the channel, and inputs that are not selected have no effect.
- R3: A tick that moves the live count from 1 to 0 sets the flag (ctl bit 15). Without reload the count then stays at 0, and later ticks set no new flag.
- R4: With reload (ctl bit 6) set, a tick at count 1 loads the period register instead of 0 and sets the flag. A tick at count 0 loads the period register without setting the flag.
- R5: With load-on-write (ctl bit 7) set, a write to the period register also puts the new value into the live counter at the same edge, and this takes precedence over a tick. With bit 7 clear, the live counter is not touched by the write.
- R6: `irq[n]` is high exactly when channel n has both its flag and its interrupt enable (ctl bit 14) set. The flag is set whether or not the enable is on.
- R7: The flag holds until it is cleared through the clear alias. If a clear and an expiry land in the same cycle, the flag stays set.
- R8: Address bits [3:2] pick the access kind: 0 writes the register, 1 (+0x4) ORs the data in, 2 (+0x8) clears the bits that are 1 in the data, 3 (+0xC) is ignored. This applies to the block, control and period registers.
- R9: The live counter (0x30 + n*0x40) is read-only, and writes to it change nothing.
- R10: Offset 0x120 always reads 0x0200_0000 (major version 2 in bits [31:24]), and writes to it have no effect.
- R11: Bit 31 of the block control register (0x00) is a soft reset. While it is set, all channel registers are held at 0 and writes to them are lost. The channels resume once software clears the bit.
- R12: A period of 2 with load-on-write, selected on every cycle, raises the interrupt exactly two clock edges after the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the alias |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_src | input | NUM_SRC | Tick enable inputs a channel can select |
| irq | output | NUM_CH | Per-channel interrupt, flag AND enable |

## Verification
Some rules are checked by the assertions on every cycle: a selected tick decrements the counter, an idle cycle leaves it unchanged, a 1-to-0 tick sets the flag, only a control write can drop the flag, a load-on-write leaves live equal to period, soft reset zeroes every channel register, and the version read returns its constant. The bench scenarios cover the rest. These are the alias arithmetic and the ignored 0xC alias, the writes to the live counter and the version word that must have no effect, reload starting from zero, the interrupt gating by the enable bit, the clear that collides with an expiry, and the exact edge at which a two-tick interval fires.

// File: rtl/tmr_pkg.sv
// Package: shared types, control bit positions and helpers for the timer bank.
// Assumes a 32-bit register word.
package tmr_pkg;

    // Kind of register access, taken from address bits [3:2]
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } wr_op_e;

    // Control bit positions that software decodes
    localparam int CTL_RELOAD = 6;
    localparam int CTL_UPDATE = 7;
    localparam int CTL_IE     = 14;
    localparam int CTL_FLAG   = 15;

    localparam logic [3:0]  SEL_ALWAYS   = 4'hF;
    localparam logic [3:0]  SEL_SRC_BASE = 4'h8;
    localparam logic [31:0] VERSION_WORD = 32'h0200_0000;

    // Stored control fields of one channel
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       update;
        logic       reload;
        logic [3:0] sel;
    } chan_ctl_t;

    // Applies a write, set or clear access to a register word
    function automatic logic [31:0] apply_op(wr_op_e op, logic [31:0] cur, logic [31:0] wd);
        case (op)
            OP_WRITE: return wd;
            OP_SET:   return cur | wd;
            OP_CLR:   return cur & ~wd;
            default:  return cur;
        endcase
    endfunction

    // Places the control fields at their bus bit positions
    function automatic logic [31:0] pack_ctl(chan_ctl_t c);
        logic [31:0] w;
        w = '0;
        w[CTL_FLAG]   = c.flag;
        w[CTL_IE]     = c.ie;
        w[CTL_UPDATE] = c.update;
        w[CTL_RELOAD] = c.reload;
        w[3:0]        = c.sel;
        return w;
    endfunction

    // Pulls the control fields out of a bus word
    function automatic chan_ctl_t unpack_ctl(logic [31:0] w);
        chan_ctl_t c;
        c.flag   = w[CTL_FLAG];
        c.ie     = w[CTL_IE];
        c.update = w[CTL_UPDATE];
        c.reload = w[CTL_RELOAD];
        c.sel    = w[3:0];
        return c;
    endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
// Address decoder: turns the bus address into register hits and an access kind.
// Assumes word-aligned accesses. Bits [1:0] are ignored, bits [3:2] pick the
// alias, and the rest name the register. Channel n sits at 0x20 + n*0x40.
module tmr_addr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output wr_op_e            op,
    output logic              blk_hit,
    output logic              ver_hit,
    output logic [NUM_CH-1:0] ctl_hit,
    output logic [NUM_CH-1:0] live_hit,
    output logic [NUM_CH-1:0] per_hit
);

    localparam logic [ADDR_W-1:0] BLK_ADDR = ADDR_W'(32'h000);
    localparam logic [ADDR_W-1:0] VER_ADDR = ADDR_W'(32'h120);

    logic [ADDR_W-1:0] base;
    logic              unused_lsb;

    assign base       = {addr[ADDR_W-1:4], 4'h0};
    assign unused_lsb = ^addr[1:0];

    // Maps the alias field to an access kind when a write is present
    always_comb begin
        op = OP_NONE;
        if (wr) begin
            case (addr[3:2])
                2'd0:    op = OP_WRITE;
                2'd1:    op = OP_SET;
                2'd2:    op = OP_CLR;
                default: op = OP_NONE;
            endcase
        end
    end

    assign blk_hit = (base == BLK_ADDR);
    assign ver_hit = (base == VER_ADDR);

    // One address compare per channel register
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ctl_hit[n]  = (base == ADDR_W'(32'h20 + n * 32'h40));
        assign live_hit[n] = (base == ADDR_W'(32'h30 + n * 32'h40));
        assign per_hit[n]  = (base == ADDR_W'(32'h40 + n * 32'h40));
    end

endmodule

// File: rtl/tmr_channel.sv
// One timer channel: control fields, period register and live down-counter.
// Assumes the decoder has already resolved its hits and the access kind.
// A soft reset holds every register at zero.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [NUM_SRC-1:0] tick_src,
    input  wr_op_e             op,
    input  logic               ctl_hit,
    input  logic               per_hit,
    input  logic [31:0]        wdata,
    output logic [31:0]        ctl_word,
    output logic [CNT_W-1:0]   live_cnt,
    output logic [CNT_W-1:0]   period_cnt,
    output logic               irq,
    output logic               tick_o,
    output logic               load_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    chan_ctl_t        ctl_q, ctl_after;
    logic [CNT_W-1:0] live_q, per_q, per_next, live_next;
    logic             ctl_wr, per_wr, tick, load, expire;
    logic [31:0]      per_word;

    assign ctl_wr   = ctl_hit && (op != OP_NONE);
    assign per_wr   = per_hit && (op != OP_NONE);
    assign per_word = apply_op(op, 32'(per_q), wdata);

    // Picks the tick enable named by the select field
    always_comb begin
        tick = 1'b0;
        if (ctl_q.sel == SEL_ALWAYS) begin
            tick = 1'b1;
        end else begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (ctl_q.sel == SEL_SRC_BASE + 4'(k)) tick = tick_src[k];
            end
        end
    end

    // Computes the next control fields and the next period value
    always_comb begin
        ctl_after = ctl_wr ? unpack_ctl(apply_op(op, pack_ctl(ctl_q), wdata)) : ctl_q;
        per_next  = per_wr ? per_word[CNT_W-1:0] : per_q;
    end

    assign load   = per_wr && ctl_q.update;
    assign expire = tick && !load && (live_q == CNT_ONE);

    // Next live count: an immediate load wins, then reload at the end or decrement
    always_comb begin
        live_next = live_q;
        if (load) begin
            live_next = per_next;
        end else if (tick) begin
            if (live_q == CNT_ONE || live_q == '0) begin
                live_next = ctl_q.reload ? per_q : '0;
            end else begin
                live_next = live_q - CNT_ONE;
            end
        end
    end

    // Register update with synchronous and soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctl_q  <= '0;
            per_q  <= '0;
            live_q <= '0;
        end else begin
            ctl_q      <= ctl_after;
            ctl_q.flag <= ctl_after.flag | expire;
            per_q      <= per_next;
            live_q     <= live_next;
        end
    end

    assign ctl_word   = pack_ctl(ctl_q);
    assign live_cnt   = live_q;
    assign period_cnt = per_q;
    assign irq        = ctl_q.flag & ctl_q.ie;
    assign tick_o     = tick;
    assign load_o     = load;

endmodule

// File: rtl/tmr_read_port.sv
// Read port: selects the addressed register and registers it on a read strobe.
// Assumes at most one hit at a time and reads that ignore the alias bits.
module tmr_read_port
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd,
    input  logic                    blk_hit,
    input  logic                    ver_hit,
    input  logic [NUM_CH-1:0]       ctl_hit,
    input  logic [NUM_CH-1:0]       live_hit,
    input  logic [NUM_CH-1:0]       per_hit,
    input  logic                    blk_rst,
    input  logic [NUM_CH-1:0][31:0] ctl_words,
    input  logic [NUM_CH-1:0][31:0] live_words,
    input  logic [NUM_CH-1:0][31:0] per_words,
    output logic [31:0]             rdata
);

    logic [31:0] rd_mux;

    // Selects the word for the current address
    always_comb begin
        rd_mux = '0;
        if (blk_hit) rd_mux = {blk_rst, 31'b0};
        if (ver_hit) rd_mux = VERSION_WORD;
        for (int n = 0; n < NUM_CH; n++) begin
            if (ctl_hit[n])  rd_mux = ctl_words[n];
            if (live_hit[n]) rd_mux = live_words[n];
            if (per_hit[n])  rd_mux = per_words[n];
        end
    end

    // Captures the selected word when a read is requested
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

endmodule

// File: rtl/tick_timer_bank.sv
// Timer bank top: decoder, block soft-reset register, NUM_CH channels, read port.
// Assumes NUM_CH is between 1 and 4, so that no channel lands on the version
// word, and NUM_SRC is 7 or fewer, so that every source gets a select code.
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] tick_src,
    output logic [NUM_CH-1:0]  irq
);

    wr_op_e                  op;
    logic                    blk_hit, ver_hit, blk_rst;
    logic [NUM_CH-1:0]       ctl_hit, live_hit, per_hit;
    logic [NUM_CH-1:0]       ch_tick, ch_load, ch_ctl_wr;
    logic [NUM_CH-1:0][31:0] ctl_words, live_words, per_words;
    logic [31:0]             blk_next;

    tmr_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .op       (op),
        .blk_hit  (blk_hit),
        .ver_hit  (ver_hit),
        .ctl_hit  (ctl_hit),
        .live_hit (live_hit),
        .per_hit  (per_hit)
    );

    assign blk_next = apply_op(op, {blk_rst, 31'b0}, bus_wdata);

    // Holds the soft-reset bit of the block control register
    always_ff @(posedge clk) begin
        if (!rst_n)                       blk_rst <= 1'b0;
        else if (blk_hit && op != OP_NONE) blk_rst <= blk_next[31];
    end

    // One channel instance per configured channel
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        tmr_channel #(.NUM_SRC(NUM_SRC), .CNT_W(32)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (blk_rst),
            .tick_src   (tick_src),
            .op         (op),
            .ctl_hit    (ctl_hit[n]),
            .per_hit    (per_hit[n]),
            .wdata      (bus_wdata),
            .ctl_word   (ctl_words[n]),
            .live_cnt   (live_words[n]),
            .period_cnt (per_words[n]),
            .irq        (irq[n]),
            .tick_o     (ch_tick[n]),
            .load_o     (ch_load[n])
        );
        assign ch_ctl_wr[n] = ctl_hit[n] && (op != OP_NONE);
    end

    tmr_read_port #(.NUM_CH(NUM_CH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (bus_rd),
        .blk_hit    (blk_hit),
        .ver_hit    (ver_hit),
        .ctl_hit    (ctl_hit),
        .live_hit   (live_hit),
        .per_hit    (per_hit),
        .blk_rst    (blk_rst),
        .ctl_words  (ctl_words),
        .live_words (live_words),
        .per_words  (per_words),
        .rdata      (bus_rdata)
    );

endmodule

// File: rtl/tick_timer_bank_chk.sv
// Checker for the timer bank, attached to every instance by the bind below.
// It observes channel state and the bus, and drives nothing.
module tick_timer_bank_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_rd,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_rdata,
    input logic                    soft_rst,
    input logic [NUM_CH-1:0]       ch_tick,
    input logic [NUM_CH-1:0]       ch_load,
    input logic [NUM_CH-1:0]       ch_ctl_wr,
    input logic [NUM_CH-1:0][31:0] ctl_words,
    input logic [NUM_CH-1:0][31:0] live_words,
    input logic [NUM_CH-1:0][31:0] per_words
);

    localparam logic [ADDR_W-5:0] VER_IDX = (ADDR_W-4)'(32'h12);

    p_version_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[ADDR_W-1:4] == VER_IDX) |=> (bus_rdata == VERSION_WORD));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[n] && !ch_load[n] && !soft_rst && live_words[n] > 32'd1)
            |=> (live_words[n] == $past(live_words[n]) - 32'd1));

        p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_tick[n] && !ch_load[n] && !soft_rst) |=> $stable(live_words[n]));

        p_expire_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[n] && !ch_load[n] && !soft_rst && live_words[n] == 32'd1)
            |=> ctl_words[n][CTL_FLAG]);

        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_words[n][CTL_FLAG] && !ch_ctl_wr[n] && !soft_rst) |=> ctl_words[n][CTL_FLAG]);

        p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_load[n] && !soft_rst) |=> (live_words[n] == per_words[n]));

        p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> (live_words[n] == '0 && ctl_words[n] == '0 && per_words[n] == '0));
    end

endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .soft_rst   (blk_rst),
    .ch_tick    (ch_tick),
    .ch_load    (ch_load),
    .ch_ctl_wr  (ch_ctl_wr),
    .ctl_words  (ctl_words),
    .live_words (live_words),
    .per_words  (per_words)
);

// File: tb/tb_tick_timer_bank.sv
// Scoreboard bench: read tasks queue expected words and a monitor compares them.
module tb_tick_timer_bank;

    localparam int NUM_CH  = 2;
    localparam int NUM_SRC = 4;
    localparam int ADDR_W  = 12;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] addr;
        string       tag;
    } sb_item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_SRC-1:0] tick_src = '0;
    logic [NUM_CH-1:0]  irq;

    int       checks = 0;
    int       failures = 0;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    tick_timer_bank #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_src  (tick_src),
        .irq       (irq)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_tick(input logic [31:0] a, input logic [31:0] d, input logic [NUM_SRC-1:0] src);
        bus_addr  = a[ADDR_W-1:0];
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick_src  = src;
        step();
        bus_wr   = 1'b0;
        tick_src = '0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        wr_tick(a, d, '0);
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] src);
        tick_src = src;
        step();
        tick_src = '0;
    endtask

    task automatic rd_exp(input logic [31:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.exp  = e;
        it.addr = a;
        it.tag  = tag;
        sb_q.push_back(it);
        bus_addr = a[ADDR_W-1:0];
        bus_rd   = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, e);
        end
    endtask

    // Monitor: pairs each registered read result with the queued expectation
    initial begin
        forever begin
            logic pend;
            @(posedge clk);
            pend = bus_rd;
            @(negedge clk);
            if (pend) begin
                if (sb_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R1 read result with empty scoreboard actual=%h expected=none", bus_rdata);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    checks++;
                    if (bus_rdata !== it.exp) begin
                        failures++;
                        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();

        // R1 reset state, R10 version word
        rd_exp(32'h000, 32'h0, "R1 blk");
        rd_exp(32'h020, 32'h0, "R1 ctl0");
        rd_exp(32'h030, 32'h0, "R1 live0");
        rd_exp(32'h040, 32'h0, "R1 per0");
        rd_exp(32'h060, 32'h0, "R1 ctl1");
        rd_exp(32'h070, 32'h0, "R1 live1");
        rd_exp(32'h080, 32'h0, "R1 per1");
        rd_exp(32'h120, 32'h0200_0000, "R10 version");
        chk(32'(irq), 32'h0, "R1 irq after reset");
        wr(32'h120, 32'hDEAD_BEEF);
        rd_exp(32'h120, 32'h0200_0000, "R10 version after write");

        // R5 load on write, R2 decrement on source 0 only
        wr(32'h020, 32'h0000_0088);
        wr(32'h040, 32'd5);
        rd_exp(32'h030, 32'd5, "R5 live copied");
        rd_exp(32'h040, 32'd5, "R5 period");
        pulse(4'b0001);
        pulse(4'b0001);
        rd_exp(32'h030, 32'd3, "R2 two ticks");
        pulse(4'b0010);
        rd_exp(32'h030, 32'd3, "R2 unselected source");

        // R9 live counter is read-only
        wr(32'h030, 32'h77);
        rd_exp(32'h030, 32'd3, "R9 live write ignored");

        // R2 undefined select freezes; R8 set/clear aliases
        wr(32'h028, 32'h8);
        wr(32'h024, 32'h5);
        pulse(4'b1111);
        rd_exp(32'h030, 32'd3, "R2 undefined select frozen");
        rd_exp(32'h020, 32'h85, "R8 set clear alias ctl");
        wr(32'h02C, 32'hFFFF_FFFF);
        rd_exp(32'h020, 32'h85, "R8 alias 0xC ignored");

        // R3 expiry without reload
        wr(32'h028, 32'h5);
        wr(32'h024, 32'h8);
        pulse(4'b0001);
        pulse(4'b0001);
        rd_exp(32'h020, 32'h88, "R3 no flag before expiry");
        pulse(4'b0001);
        rd_exp(32'h020, 32'h8088, "R3 flag at expiry");
        rd_exp(32'h030, 32'h0, "R3 live at zero");
        chk(32'(irq[0]), 32'h0, "R6 flag without enable keeps irq low");
        pulse(4'b0001);
        pulse(4'b0001);
        rd_exp(32'h030, 32'h0, "R3 stays at zero");
        wr(32'h028, 32'h8000);
        rd_exp(32'h020, 32'h88, "R7 clear alias drops flag");
        pulse(4'b0001);
        pulse(4'b0001);
        rd_exp(32'h020, 32'h88, "R3 no second flag");

        // R6 interrupt gating
        wr(32'h024, 32'h4000);
        wr(32'h040, 32'd3);
        pulse(4'b0001);
        pulse(4'b0001);
        chk(32'(irq[0]), 32'h0, "R6 irq low before expiry");
        pulse(4'b0001);
        chk(32'(irq[0]), 32'h1, "R6 irq high on expiry");
        chk(32'(irq[1]), 32'h0, "R6 other channel quiet");
        wr(32'h028, 32'h4000);
        chk(32'(irq[0]), 32'h0, "R6 irq masked by enable");
        rd_exp(32'h020, 32'h8088, "R6 flag kept while masked");
        wr(32'h024, 32'h4000);
        chk(32'(irq[0]), 32'h1, "R6 irq back on enable");
        wr(32'h028, 32'h8000);
        chk(32'(irq[0]), 32'h0, "R7 irq drops after clear");

        // R4 reload, R5 no copy without update
        wr(32'h020, 32'h0000_4048);
        wr(32'h040, 32'd3);
        rd_exp(32'h030, 32'h0, "R5 no copy without update");
        pulse(4'b0001);
        rd_exp(32'h030, 32'd3, "R4 reload from zero");
        rd_exp(32'h020, 32'h4048, "R4 no flag on zero reload");
        pulse(4'b0001);
        pulse(4'b0001);
        pulse(4'b0001);
        rd_exp(32'h030, 32'd3, "R4 reload at expiry");
        rd_exp(32'h020, 32'hC048, "R4 flag at reload expiry");

        // R7 clear colliding with expiry keeps the flag
        wr(32'h028, 32'h8000);
        rd_exp(32'h020, 32'h4048, "R7 flag cleared");
        pulse(4'b0001);
        pulse(4'b0001);
        wr_tick(32'h028, 32'h8000, 4'b0001);
        rd_exp(32'h020, 32'hC048, "R7 expiry wins over clear");
        rd_exp(32'h030, 32'd3, "R4 reload after collision");

        // R12 minimum two-tick interval on channel 1 counting every cycle
        wr(32'h060, 32'h0000_408F);
        wr(32'h080, 32'd2);
        chk(32'(irq[1]), 32'h0, "R12 irq low at load edge");
        step();
        chk(32'(irq[1]), 32'h0, "R12 irq low after one tick");
        step();
        chk(32'(irq[1]), 32'h1, "R12 irq high after two ticks");
        rd_exp(32'h070, 32'h0, "R3 always-tick channel stops at zero");

        // R8 period aliases
        wr(32'h084, 32'h100);
        rd_exp(32'h080, 32'h102, "R8 period set alias");
        wr(32'h088, 32'h2);
        rd_exp(32'h080, 32'h100, "R8 period clear alias");

        // R11 soft reset
        wr(32'h004, 32'h8000_0000);
        rd_exp(32'h000, 32'h8000_0000, "R11 soft reset bit set");
        rd_exp(32'h020, 32'h0, "R11 ctl0 cleared");
        rd_exp(32'h040, 32'h0, "R11 per0 cleared");
        rd_exp(32'h030, 32'h0, "R11 live0 cleared");
        rd_exp(32'h060, 32'h0, "R11 ctl1 cleared");
        chk(32'(irq), 32'h0, "R11 irq cleared");
        wr(32'h040, 32'd9);
        rd_exp(32'h040, 32'h0, "R11 write lost in reset");
        wr(32'h008, 32'h8000_0000);
        rd_exp(32'h000, 32'h0, "R11 soft reset released");
        wr(32'h040, 32'd9);
        rd_exp(32'h040, 32'd9, "R11 writes resume");

        step();
        step();
        if (sb_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R1 pending reads actual=%0d expected=0", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule